// File: doc/BRIEF.md
# Eight-Channel Serial Converter Register Front End

This block is the digital side of an eight-channel data converter. A host sends 32-bit words over a three-wire serial link: an active-low select, a serial clock and a data line. Each complete word is decoded into an operation code, a channel address and a 16-bit value. Every channel has two registers. The staging register receives new values. The output register drives the converter. Outputs can change one channel at a time, all at once from a shared load strobe, or immediately when the strobe is tied low.

The three serial pins, the load strobe and the clear input are all sampled into the system clock domain through two-flop synchronizers, and their edges are detected there. A falling edge on the clear input overwrites the staging and output registers of every channel with a selectable clear value: zero, midscale or full scale. For as long as the clear input stays low, the load strobe has no effect.

Top module: `dac_frontend`

## Requirements
- R1: A word starts when `sel_n` falls. Exactly 32 falling edges of `sclk` follow, and each one samples `sdi`, most significant bit first. The word then takes effect. Further `sclk` edges before `sel_n` rises are ignored. Word layout: bits 27:24 operation, bits 23:20 address, bits 19:4 value, and the remaining bits are ignored.
- R2: If `sel_n` rises before the 32nd falling `sclk` edge, the partial word is discarded and no register changes.
- R3: Operation 0 writes the staging register of the addressed channel and marks that channel pending. The output is unchanged while `load_n` is high.
- R4: While `load_n` is low and `clr_n` is high, every pending channel copies its staging register into its output register in the same cycle, and its pending mark is cleared. A low pulse on `load_n` therefore updates all pending channels together.
- R5: With `load_n` held low, a channel written by operation 0 shows the new value on its output without any further action.
- R6: Operation 1 copies the addressed staging register to its output. Operation 3 writes both registers of the addressed channel. Operation 2 writes the addressed staging register and then copies all eight staging registers to their outputs.
- R7: Address 15 selects all eight channels. Addresses 0 to 7 select one channel. Addresses 8 to 14 select none.
- R8: A falling edge of `clr_n` loads the staging and output registers of all channels with the clear value and clears every pending mark.
- R9: While `clr_n` is low, `load_n` is ignored. Pending marks set during that time remain and take effect at a later load.
- R10: Operation 5 sets the clear code from value bits 1:0: 00 gives 0x0000, 01 gives 0x8000, 10 gives 0xFFFF. Code 11 leaves the code unchanged. Other operation codes have no effect.
- R11: After reset, all staging and output registers are 0 and the clear code is 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Serial word select, active low |
| sclk | input | 1 | Serial clock, idles high, data sampled on falling edge |
| sdi | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Output load strobe, active low |
| clr_n | input | 1 | Clear input, acts on falling edge |
| dac_out | output | 128 | Eight 16-bit output registers, channel i at bits i*16+15 : i*16 |

## Verification
The hardest state to reach is a channel that is marked pending while `clr_n` is held low. A load pulse must leave its output untouched, and the mark must survive so that a later load, after release, still moves the value. The stimulus reaches this state in four steps. It first programs a nonzero clear code, then drops `clr_n`, then sends a full write word and pulses `load_n`. Last, it releases `clr_n` and pulses `load_n` again, and the output is checked after each step. Aborted words are produced by raising `sel_n` after 20 clocks. Surplus clocks are produced by keeping `sel_n` low for four extra edges past the 32nd.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    localparam int FRAME_W = 32;
    localparam int OP_W    = 4;
    localparam int ADR_W   = 4;
    localparam int PAD_LO  = 4;

    typedef enum logic [OP_W-1:0] {
        OP_WR_IN       = 4'd0,
        OP_UPD_OUT     = 4'd1,
        OP_WR_UPD_ALL  = 4'd2,
        OP_WR_UPD_ONE  = 4'd3,
        OP_SET_CLR     = 4'd5
    } op_e;

    localparam logic [ADR_W-1:0] ADR_ALL = 4'hF;

    localparam logic [1:0] CLR_ZERO = 2'b00;
    localparam logic [1:0] CLR_MID  = 2'b01;
    localparam logic [1:0] CLR_FULL = 2'b10;
    localparam logic [1:0] CLR_BAD  = 2'b11;

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/dacfe_rx.sv
module dacfe_rx
    import dacfe_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_s,
    input  logic               sclk_s,
    input  logic               sdi_s,
    output logic               frm_vld,
    output logic [FRAME_W-1:0] frm_word
);
    localparam int CW = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
        logic [CW-1:0]      cnt;
        logic               act;
        logic               sclk_p;
        logic               sel_p;
        logic               vld;
    } rx_t;

    rx_t d, q;
    logic sel_fall, sclk_fall;

    always_comb begin
        d        = q;
        d.vld    = 1'b0;
        d.sclk_p = sclk_s;
        d.sel_p  = sel_s;
        sel_fall  = q.sel_p & ~sel_s;
        sclk_fall = q.sclk_p & ~sclk_s;
        if (sel_fall) begin
            d.act = 1'b1;
            d.cnt = '0;
        end else if (q.act) begin
            if (sel_s) begin
                d.act = 1'b0;
            end else if (sclk_fall) begin
                d.shreg = {q.shreg[FRAME_W-2:0], sdi_s};
                if (q.cnt == CW'(FRAME_W - 1)) begin
                    d.vld = 1'b1;
                    d.act = 1'b0;
                    d.cnt = CW'(FRAME_W);
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.sclk_p <= 1'b1;
            q.sel_p  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign frm_vld  = q.vld;
    assign frm_word = q.shreg;
endmodule

// File: rtl/dacfe_bank.sv
module dacfe_bank
    import dacfe_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frm_vld,
    input  logic [FRAME_W-1:0] frm_word,
    input  logic               load_act,
    input  logic               clr_fall,
    input  logic               clr_low,
    output logic [NCH*DW-1:0]  out_bus,
    output logic [NCH-1:0]     pend,
    output logic [1:0]         code
);
    localparam int DAT_LSB = PAD_LO;
    localparam int ADR_LSB = DAT_LSB + DW;
    localparam int OP_LSB  = ADR_LSB + ADR_W;
    localparam int TOP_LSB = OP_LSB + OP_W;

    typedef struct packed {
        logic [NCH-1:0][DW-1:0] inr;
        logic [NCH-1:0][DW-1:0] outr;
        logic [NCH-1:0]         pend;
        logic [1:0]             code;
    } bank_t;

    bank_t d, q;

    logic [DW-1:0]    wdata;
    logic [ADR_W-1:0] adr;
    op_e              op;
    logic [NCH-1:0]   hit;
    logic [DW-1:0]    cval;
    logic             unused_bits;

    assign wdata = frm_word[DAT_LSB +: DW];
    assign adr   = frm_word[ADR_LSB +: ADR_W];
    assign op    = op_e'(frm_word[OP_LSB +: OP_W]);
    assign unused_bits = ^{frm_word[FRAME_W-1:TOP_LSB], frm_word[PAD_LO-1:0]};

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            hit[i] = (adr == ADR_ALL) || (adr == ADR_W'(i));
        end
    end

    always_comb begin
        case (q.code)
            CLR_MID:  cval = {1'b1, {(DW-1){1'b0}}};
            CLR_FULL: cval = '1;
            default:  cval = '0;
        endcase
    end

    always_comb begin
        d = q;
        if (clr_fall) begin
            for (int i = 0; i < NCH; i++) begin
                d.inr[i]  = cval;
                d.outr[i] = cval;
            end
            d.pend = '0;
        end else begin
            if (frm_vld) begin
                case (op)
                    OP_WR_IN: begin
                        for (int i = 0; i < NCH; i++) begin
                            if (hit[i]) begin
                                d.inr[i]  = wdata;
                                d.pend[i] = 1'b1;
                            end
                        end
                    end
                    OP_UPD_OUT: begin
                        for (int i = 0; i < NCH; i++) begin
                            if (hit[i]) begin
                                d.outr[i] = q.inr[i];
                                d.pend[i] = 1'b0;
                            end
                        end
                    end
                    OP_WR_UPD_ALL: begin
                        for (int i = 0; i < NCH; i++) begin
                            if (hit[i]) d.inr[i] = wdata;
                        end
                        for (int i = 0; i < NCH; i++) begin
                            d.outr[i] = d.inr[i];
                        end
                        d.pend = '0;
                    end
                    OP_WR_UPD_ONE: begin
                        for (int i = 0; i < NCH; i++) begin
                            if (hit[i]) begin
                                d.inr[i]  = wdata;
                                d.outr[i] = wdata;
                                d.pend[i] = 1'b0;
                            end
                        end
                    end
                    OP_SET_CLR: begin
                        if (wdata[1:0] != CLR_BAD) d.code = wdata[1:0];
                    end
                    default: ;
                endcase
            end
            if (load_act && !clr_low) begin
                for (int i = 0; i < NCH; i++) begin
                    if (d.pend[i]) begin
                        d.outr[i] = d.inr[i];
                        d.pend[i] = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_bus = q.outr;
    assign pend    = q.pend;
    assign code    = q.code;
endmodule

// File: rtl/dac_frontend.sv
module dac_frontend
    import dacfe_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              load_n,
    input  logic              clr_n,
    output logic [NCH*DW-1:0] dac_out
);
    localparam int NSYNC = 5;

    logic [NSYNC-1:0]   pins_s;
    logic               sel_s, sclk_s, sdi_s, load_s, clr_s;
    logic               frm_vld;
    logic [FRAME_W-1:0] frm_word;
    logic               clr_p_d, clr_p_q;
    logic               clr_fall, clr_low, load_act;
    logic [NCH-1:0]     pend_w;
    logic [1:0]         code_w;

    dacfe_sync #(.W(NSYNC), .RST_VAL(5'b11011)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sel_n, sclk, sdi, load_n, clr_n}),
        .q     (pins_s)
    );

    assign {sel_s, sclk_s, sdi_s, load_s, clr_s} = pins_s;

    always_comb begin
        clr_p_d  = clr_s;
        clr_fall = clr_p_q & ~clr_s;
        clr_low  = ~clr_s;
        load_act = ~load_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clr_p_q <= 1'b1;
        else        clr_p_q <= clr_p_d;
    end

    dacfe_rx i_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_s    (sel_s),
        .sclk_s   (sclk_s),
        .sdi_s    (sdi_s),
        .frm_vld  (frm_vld),
        .frm_word (frm_word)
    );

    dacfe_bank #(.NCH(NCH), .DW(DW)) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_vld  (frm_vld),
        .frm_word (frm_word),
        .load_act (load_act),
        .clr_fall (clr_fall),
        .clr_low  (clr_low),
        .out_bus  (dac_out),
        .pend     (pend_w),
        .code     (code_w)
    );
endmodule

// File: rtl/dac_frontend_chk.sv
module dac_frontend_chk #(
    parameter int NCH = 8,
    parameter int DW  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frm_vld,
    input logic              clr_fall,
    input logic              clr_low,
    input logic              load_act,
    input logic [NCH-1:0]    pend,
    input logic [1:0]        code,
    input logic [NCH*DW-1:0] dac_out
);
    function automatic logic [DW-1:0] clr_word(input logic [1:0] c);
        case (c)
            2'b01:   return {1'b1, {(DW-1){1'b0}}};
            2'b10:   return '1;
            default: return '0;
        endcase
    endfunction

    // R1: a completed word is a single-cycle event
    a_r1_single_word: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld |=> !frm_vld);

    // R2: with no word, load or clear, outputs hold
    a_r2_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!frm_vld && !load_act && !clr_fall) |=> $stable(dac_out));

    // R4: an accepted load leaves nothing pending
    a_r4_pend_drained: assert property (@(posedge clk) disable iff (!rst_n)
        (load_act && !clr_low && !clr_fall) |=> (pend == '0));

    // R8: clear empties all pending marks
    a_r8_pend_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fall |=> (pend == '0));

    // R9: load is locked out while clear is low
    a_r9_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_low && !clr_fall && !frm_vld) |=> $stable(dac_out));

    // R10: the reserved clear code is never stored
    a_r10_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        code != 2'b11);

    for (genvar g = 0; g < NCH; g++) begin : g_clr
        // R8: every channel takes the clear value
        a_r8_clear_value: assert property (@(posedge clk) disable iff (!rst_n)
            clr_fall |=> (dac_out[g*DW +: DW] == clr_word($past(code))));
    end
endmodule

bind dac_frontend dac_frontend_chk #(.NCH(NCH), .DW(DW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frm_vld  (frm_vld),
    .clr_fall (clr_fall),
    .clr_low  (clr_low),
    .load_act (load_act),
    .pend     (pend_w),
    .code     (code_w),
    .dac_out  (dac_out)
);

// File: tb/test_dac_frontend.sv
`timescale 1ns/1ps
module test_dac_frontend;
    localparam int NCH = 8;
    localparam int DW  = 16;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, sclk = 1'b1, sdi = 1'b0, load_n = 1'b1, clr_n = 1'b1;
    logic [NCH*DW-1:0] dac_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dac_frontend #(.NCH(NCH), .DW(DW)) i_dac_frontend (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
        .load_n(load_n), .clr_n(clr_n), .dac_out(dac_out)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int ch, input logic [DW-1:0] exp);
        logic [DW-1:0] act;
        act = dac_out[ch*DW +: DW];
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s ch%0d actual=%h expected=%h", req, ch, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [DW-1:0] exp);
        for (int i = 0; i < NCH; i++) check(req, i, exp);
    endtask

    task automatic send_bits(input logic [31:0] w, input int nbits, input int extra);
        sel_n = 1'b0;
        wait_clk(HALF);
        for (int b = 0; b < nbits + extra; b++) begin
            sdi = (b < nbits) ? w[31-b] : 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
            wait_clk(HALF);
            sclk = 1'b1;
        end
        wait_clk(HALF);
        sel_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic send(input logic [3:0] op, input logic [3:0] adr, input logic [15:0] val);
        send_bits({4'h0, op, adr, val, 4'h0}, 32, 0);
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        wait_clk(5);
        load_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic t_reset();
        check_all("R11 reset", 16'h0000);
    endtask

    task automatic t_write_hold();
        send(4'd0, 4'd2, 16'h1234);
        check("R3 write holds output", 2, 16'h0000);
        pulse_load();
        check("R4 load moves pending", 2, 16'h1234);
    endtask

    task automatic t_single_update();
        send(4'd0, 4'd1, 16'hAAAA);
        send(4'd0, 4'd3, 16'h3333);
        send(4'd1, 4'd1, 16'h0000);
        check("R6 op1 updates addressed", 1, 16'hAAAA);
        check("R6 op1 leaves others", 3, 16'h0000);
        pulse_load();
        check("R4 load moves remaining pending", 3, 16'h3333);
    endtask

    task automatic t_write_update_one();
        send(4'd3, 4'd5, 16'h5555);
        check("R6 op3 writes and updates", 5, 16'h5555);
        send(4'd3, 4'd9, 16'h7777);
        check("R7 address 9 selects none", 5, 16'h5555);
        check("R7 address 9 selects none", 0, 16'h0000);
        send(4'd7, 4'd5, 16'h7777);
        check("R10 unused op ignored", 5, 16'h5555);
    endtask

    task automatic t_write_update_all();
        send(4'd0, 4'd4, 16'h4444);
        check("R3 op0 holds output", 4, 16'h0000);
        send(4'd2, 4'd0, 16'h0F0F);
        check("R6 op2 writes addressed", 0, 16'h0F0F);
        check("R6 op2 updates all", 4, 16'h4444);
        check("R6 op2 updates all", 1, 16'hAAAA);
    endtask

    task automatic t_broadcast();
        send(4'd3, 4'd15, 16'h2222);
        check_all("R7 broadcast", 16'h2222);
    endtask

    task automatic t_abort_and_extra();
        send_bits({4'h0, 4'd3, 4'd6, 16'h9999, 4'h0}, 20, 0);
        check("R2 aborted word discarded", 6, 16'h2222);
        send(4'd3, 4'd6, 16'h6666);
        check("R1 full word after abort", 6, 16'h6666);
        send_bits({4'h0, 4'd3, 4'd7, 16'hABCD, 4'h0}, 32, 4);
        check("R1 surplus clocks ignored", 7, 16'hABCD);
    endtask

    task automatic t_load_low();
        load_n = 1'b0;
        wait_clk(5);
        send(4'd0, 4'd1, 16'h1111);
        check("R5 held load updates at once", 1, 16'h1111);
        load_n = 1'b1;
        wait_clk(5);
    endtask

    task automatic t_clear();
        clr_n = 1'b0;
        wait_clk(10);
        check_all("R8 R10 default clear zero", 16'h0000);
        clr_n = 1'b1;
        wait_clk(5);
        send(4'd1, 4'd3, 16'h0000);
        check("R8 staging register cleared", 3, 16'h0000);
        send(4'd5, 4'd0, 16'h0001);
        send(4'd5, 4'd0, 16'h0003);
        clr_n = 1'b0;
        wait_clk(10);
        check_all("R10 midscale, code 11 ignored", 16'h8000);
        send(4'd0, 4'd2, 16'h0202);
        pulse_load();
        check("R9 load ignored while clear low", 2, 16'h8000);
        clr_n = 1'b1;
        wait_clk(5);
        pulse_load();
        check("R9 pending survives clear low", 2, 16'h0202);
        send(4'd5, 4'd0, 16'h0002);
        clr_n = 1'b0;
        wait_clk(10);
        check_all("R10 full scale", 16'hFFFF);
        clr_n = 1'b1;
        wait_clk(5);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_write_hold();
        t_single_update();
        t_write_update_one();
        t_write_update_all();
        t_broadcast();
        t_abort_and_extra();
        t_load_low();
        t_clear();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule